// File: doc/BRIEF.md
# Branch Direction Predictor with Selectable Strategy

This block guesses whether a conditional branch will be taken. It keeps a small direct-mapped table of per-branch history, selected by the low word-address bits of the program counter. A lookup port returns a guess in the same cycle. An update port reports the real outcome of a resolved branch so that the history can learn from it.

A two-bit mode input picks the guessing strategy at run time:
- a fixed "taken" guess;
- a one-bit record of the last outcome;
- a four-state two-bit machine.

The four-state machine is not a saturating counter. From the weak not-taken state, one taken outcome jumps straight to the strong taken state.

Both kinds of history are trained on every update, whatever the mode, so switching modes needs no warm-up. Two saturating counters tally correct and wrong guesses, so that the accuracy of each strategy can be measured on a workload.

Top module: `bp_predictor`

## Requirements
- R1: After reset, every entry holds two-bit state A and one-bit history "taken", and both tally counters read zero.
- R2: With mode 00, the lookup output is 1 (taken) for every PC, whatever the history holds.
- R3: With mode 01, the lookup output equals the most recent outcome written by a valid update to the same entry. Entries are independent of one another.
- R4: With mode 10 or 11, the guess is taken in states A and B and not taken in states C and D. The transitions are:
  - A: taken stays in A, not taken goes to B;
  - B: taken goes to A, not taken goes to D;
  - C: taken goes to A, not taken goes to D;
  - D: taken goes to C, not taken stays in D.
- R5: The lookup is combinational. When a lookup and an update hit the same entry in one cycle, the lookup returns the value held before the update. The new value is visible after the clock edge.
- R6: On each valid update, the guess that the current mode gives for that entry before the update is compared with the outcome. A match adds one to the hit counter; a mismatch adds one to the miss counter.
- R7: Each counter is 16 bits wide and holds at 65535 instead of wrapping. The other counter keeps counting.
- R8: The one-bit history and the two-bit state are both updated on every valid update, in every mode.
- R9: The entry index is PC bits [IDX_W+1:2] (bits [5:2] by default). PCs that differ only outside these bits share an entry.
- R10: While the update-valid input is low, no history and no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Strategy: 00 fixed taken, 01 last outcome, 10/11 four-state machine |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Guess for lk_pc, 1 = taken |
| up_valid | input | 1 | An update is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| hit_cnt | output | CNT_W | Count of correct guesses, saturating |
| miss_cnt | output | CNT_W | Count of wrong guesses, saturating |

## Verification
One entry is driven through the outcome sequences that reach every transition of the four-state machine. This includes a taken outcome from C, which tells this machine apart from a saturating counter that would stop in B. The same entry is then read in last-outcome mode and fixed-taken mode. That shows the one-bit history was trained while the other modes were active, and that the fixed mode ignores the history. Lookups with updates held off, a fresh neighbouring entry and an aliasing PC with a high bit set separate per-entry storage from the index decode. A same-cycle read and write, and a long run of hits past 65535, expose ordering and wrap-around faults.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    ST_A = 2'd0,
    ST_B = 2'd1,
    ST_C = 2'd2,
    ST_D = 2'd3
  } hist2_t;

  typedef enum logic [1:0] {
    MODE_FIXED   = 2'd0,
    MODE_LAST    = 2'd1,
    MODE_TWO     = 2'd2,
    MODE_TWO_ALT = 2'd3
  } mode_t;

  // Next state of the four-state machine
  function automatic hist2_t two_bit_next(input hist2_t s, input logic taken);
    hist2_t n;
    case (s)
      ST_A:    n = taken ? ST_A : ST_B;
      ST_B:    n = taken ? ST_A : ST_D;
      ST_C:    n = taken ? ST_A : ST_D;
      default: n = taken ? ST_C : ST_D;
    endcase
    return n;
  endfunction

  function automatic logic two_bit_guess(input hist2_t s);
    return (s == ST_A) || (s == ST_B);
  endfunction

  // Guess under a given mode from the stored history
  function automatic logic choose_guess(input logic [1:0] mode, input hist2_t s,
                                        input logic last);
    logic g;
    case (mode_t'(mode))
      MODE_FIXED: g = 1'b1;
      MODE_LAST:  g = last;
      default:    g = two_bit_guess(s);
    endcase
    return g;
  endfunction

endpackage

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output hist2_t           rd_st,
  output logic             rd_last,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output hist2_t           wr_st_old,
  output logic             wr_last_old
);
  localparam int DEPTH = 1 << IDX_W;

  hist2_t           st_q [DEPTH];
  logic [DEPTH-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_A;
      last_q <= '1;
    end else if (wr_en) begin
      st_q[wr_idx]   <= two_bit_next(st_q[wr_idx], wr_taken);
      last_q[wr_idx] <= wr_taken;
    end
  end

  assign rd_st       = st_q[rd_idx];
  assign rd_last     = last_q[rd_idx];
  assign wr_st_old   = st_q[wr_idx];
  assign wr_last_old = last_q[wr_idx];

  // R4: a taken outcome out of C lands in A, not in B
  a_r4_c_taken_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_st_old == ST_C && wr_taken) |=> (st_q[$past(wr_idx)] == ST_A));

  // R4: a not-taken outcome out of B skips C and goes to D
  a_r4_b_not_to_d: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_st_old == ST_B && !wr_taken) |=> (st_q[$past(wr_idx)] == ST_D));

  // R8: the one-bit history records every valid outcome
  a_r8_last_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (last_q[$past(wr_idx)] == $past(wr_taken)));

  // R10: no update means no history change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(last_q));

endmodule

// File: rtl/bp_tally.sv
module bp_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             score_en,
  input  logic             correct,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  wire hit_ev  = score_en &&  correct;
  wire miss_ev = score_en && !correct;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
    end else begin
      if (hit_ev)  hit_cnt  <= sat_inc(hit_cnt);
      if (miss_ev) miss_cnt <= sat_inc(miss_cnt);
    end
  end

  // R6: at most one counter moves per update
  a_r6_one_moves: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !(hit_cnt != $past(hit_cnt) && miss_cnt != $past(miss_cnt)));

  // R6: a correct guess below the ceiling adds exactly one
  a_r6_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ev && hit_cnt != CNT_MAX) |=> (hit_cnt == $past(hit_cnt) + 1'b1));

  // R7: no wrap at the ceiling
  a_r7_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cnt == CNT_MAX) |=> (hit_cnt == CNT_MAX));
  a_r7_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt == CNT_MAX) |=> (miss_cnt == CNT_MAX));

  // R10: no update means both counters stand still
  a_r10_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !score_en |=> ($stable(hit_cnt) && $stable(miss_cnt)));

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_taken,
  input  logic             up_valid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic             up_taken,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;

  logic [IDX_W-1:0] lk_idx, up_idx;
  hist2_t           lk_st, up_st_old;
  logic             lk_last, up_last_old;
  logic             up_guess_old;
  logic             up_correct;

  assign lk_idx = lk_pc[IDX_HI:IDX_LO];
  assign up_idx = up_pc[IDX_HI:IDX_LO];

  bp_table #(.IDX_W(IDX_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_idx      (lk_idx),
    .rd_st       (lk_st),
    .rd_last     (lk_last),
    .wr_en       (up_valid),
    .wr_idx      (up_idx),
    .wr_taken    (up_taken),
    .wr_st_old   (up_st_old),
    .wr_last_old (up_last_old)
  );

  assign lk_taken     = choose_guess(mode, lk_st, lk_last);
  assign up_guess_old = choose_guess(mode, up_st_old, up_last_old);
  assign up_correct   = (up_guess_old == up_taken);

  bp_tally #(.CNT_W(CNT_W)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .score_en (up_valid),
    .correct  (up_correct),
    .hit_cnt  (hit_cnt),
    .miss_cnt (miss_cnt)
  );

  // R2: the fixed mode always guesses taken
  a_r2_fixed_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> lk_taken);

  // R5: reading the entry just written shows the new outcome in last-outcome mode
  a_r5_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && mode == 2'b01 && lk_pc == up_pc) |=>
      ((mode == 2'b01 && lk_pc == $past(lk_pc) && !$past(up_valid, 2))
        -> (lk_taken == $past(up_taken))));

endmodule

// File: tb/bp_predictor_bench.sv
module bp_predictor_bench;
  localparam int PC_W  = 32;
  localparam int CNT_W = 16;
  localparam int NVEC  = 22;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'b10;
  logic [PC_W-1:0]  lk_pc = '0;
  logic             lk_taken;
  logic             up_valid = 1'b0;
  logic [PC_W-1:0]  up_pc = '0;
  logic             up_taken = 1'b0;
  logic [CNT_W-1:0] hit_cnt, miss_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bp_predictor u_bp_predictor (
    .clk(clk), .rst_n(rst_n), .mode(mode), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
  );

  // Vector: {mode[1:0], valid, pc[7:0], taken, expected guess}
  typedef logic [12:0] vec_t;
  localparam vec_t VECS [NVEC] = '{
    {2'd2, 1'b1, 8'h04, 1'b1, 1'b1},  //  0 R4 A-T->A hit
    {2'd2, 1'b1, 8'h04, 1'b0, 1'b1},  //  1 R4 A-N->B miss
    {2'd2, 1'b1, 8'h04, 1'b0, 1'b1},  //  2 R4 B-N->D miss
    {2'd2, 1'b1, 8'h04, 1'b1, 1'b0},  //  3 R4 D-T->C miss
    {2'd2, 1'b1, 8'h04, 1'b1, 1'b0},  //  4 R4 C-T->A miss
    {2'd2, 1'b1, 8'h04, 1'b0, 1'b1},  //  5 R4 A guess taken, ->B miss
    {2'd2, 1'b1, 8'h04, 1'b1, 1'b1},  //  6 R4 B-T->A hit
    {2'd2, 1'b1, 8'h04, 1'b0, 1'b1},  //  7 A->B miss
    {2'd2, 1'b1, 8'h04, 1'b0, 1'b1},  //  8 B->D miss
    {2'd2, 1'b1, 8'h04, 1'b0, 1'b0},  //  9 R4 D-N->D hit
    {2'd3, 1'b1, 8'h04, 1'b1, 1'b0},  // 10 R4 mode 11, D-T->C miss
    {2'd3, 1'b1, 8'h04, 1'b0, 1'b0},  // 11 R4 C-N->D hit
    {2'd1, 1'b1, 8'h04, 1'b1, 1'b0},  // 12 R8 last=N learnt in mode 1x, miss
    {2'd1, 1'b1, 8'h04, 1'b0, 1'b1},  // 13 R3 last=T miss
    {2'd1, 1'b1, 8'h04, 1'b0, 1'b0},  // 14 R3 last=N hit
    {2'd0, 1'b1, 8'h04, 1'b0, 1'b1},  // 15 R2 fixed taken miss
    {2'd0, 1'b1, 8'h04, 1'b1, 1'b1},  // 16 R2 hit; state D->C, last T
    {2'd2, 1'b0, 8'h04, 1'b1, 1'b0},  // 17 R10 no update, state C
    {2'd2, 1'b1, 8'h04, 1'b0, 1'b0},  // 18 R8 C-N->D hit, last N
    {2'd1, 1'b0, 8'h04, 1'b1, 1'b0},  // 19 R10 last still N
    {2'd1, 1'b0, 8'h08, 1'b0, 1'b1},  // 20 R3 other entry untouched
    {2'd2, 1'b0, 8'h44, 1'b0, 1'b0}   // 21 R9 0x44 aliases entry 1 (state D)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; up_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1: reset state across all entries in both history modes
    for (int i = 0; i < 16; i++) begin
      lk_pc = 32'(i * 4);
      mode = 2'b10; #1 check("R1 two-bit reset guess", 32'(lk_taken), 1);
      mode = 2'b01; #1 check("R1 one-bit reset guess", 32'(lk_taken), 1);
    end
    check("R1 hit reset", 32'(hit_cnt), 0);
    check("R1 miss reset", 32'(miss_cnt), 0);

    // Vector walk: guess checked before the edge that applies the update
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      mode     = VECS[v][12:11];
      up_valid = VECS[v][10];
      up_pc    = 32'(VECS[v][9:2]);
      lk_pc    = 32'(VECS[v][9:2]);
      up_taken = VECS[v][1];
      #1 check($sformatf("R4/R3/R2 vector %0d guess", v), 32'(lk_taken), 32'(VECS[v][0]));
    end
    @(negedge clk);
    up_valid = 1'b0;
    check("R6 hit count", 32'(hit_cnt), 7);
    check("R6 miss count", 32'(miss_cnt), 11);

    // R5: same-cycle read and write of entry 3 in last-outcome mode
    mode = 2'b01; lk_pc = 32'h0C; up_pc = 32'h0C; up_taken = 1'b0; up_valid = 1'b1;
    #1 check("R5 pre-update value", 32'(lk_taken), 1);
    @(negedge clk);
    up_valid = 1'b0;
    #1 check("R5 post-update value", 32'(lk_taken), 0);

    // R7: hit counter saturates while the miss counter still moves
    do_reset();
    mode = 2'b00; up_pc = 32'h10; up_taken = 1'b1; up_valid = 1'b1;
    for (int k = 0; k < 65540; k++) @(negedge clk);
    up_valid = 1'b0;
    check("R7 hit saturated", 32'(hit_cnt), 65535);
    check("R7 miss untouched", 32'(miss_cnt), 0);
    up_taken = 1'b0; up_valid = 1'b1;
    @(negedge clk);
    up_valid = 1'b0;
    @(negedge clk);
    check("R7 hit held", 32'(hit_cnt), 65535);
    check("R7 miss counted", 32'(miss_cnt), 1);

    // R1: reset clears the counters again
    do_reset();
    check("R1 hit cleared", 32'(hit_cnt), 0);
    check("R1 miss cleared", 32'(miss_cnt), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule